// File: doc/BRIEF.md
# Bus Demultiplexer and Memory Decoder

This block sits on the slave side of a processor bus whose low address byte and data byte share the same eight wires. The bus master raises an address strobe while the shared wires carry the low address byte. The block passes that byte straight through while the strobe is high and holds it once the strobe falls. The held byte is combined with the separately driven high address byte into a full 16-bit address. The data phase is framed by an enable phase signal, E, and a read/write line, where 1 means read.

From the rebuilt address the block produces gated selects for a fixed memory map. There are four 1K RAM banks at the bottom of the map and four 4K ROM banks at the top, which include the start-up vectors. The I/O window is the 4K page starting at $8000. In that window one address bit chooses between an 8-bit output register and an 8-bit input port. The input port places the external pins onto the shared wires during a read.

A parameter chooses full RAM decoding or partial decoding. Partial decoding makes RAM answer throughout the lower half of the map. The memory arrays live outside the block. All inputs are sampled on one system clock that runs much faster than E.

Top module: `bus_demux_decoder`

## Requirements
- R1: `addr[15:8]` always equals `addr_hi`. `addr[7:0]` equals `ad_in` while `as_strobe` is 1, and holds the value from the last clock in which `as_strobe` was 1 for as long as `as_strobe` stays 0. The held byte is 0 after reset.
- R2: RAM bank i (`ram_cs[i]`) is selected only while `e_phase` is 1 and the address lies in the RAM region, with i = address bits 11:10.
- R3: With `FULL_RAM_DECODE`=1 the RAM region is exactly $0000-$0FFF (bits 15:12 all zero). With `FULL_RAM_DECODE`=0 only bit 15 = 0 is required, so $1000-$7FFF mirror the four banks.
- R4: ROM bank i (`rom_cs[i]`) is selected for read and write cycles while `e_phase` is 1 and the address lies in $C000-$FFFF, with i = address bits 13:12 ($Cxxx gives bank 0 and $Fxxx gives bank 3).
- R5: `rom_oe` is 1 exactly when a ROM select is active and `rw` is 1. `ram_we` is 1 exactly when a RAM select is active and `rw` is 0.
- R6: A write cycle (`rw`=0) to $8xxx with address bit 2 = 0 loads `out_port` with the `ad_in` value sampled in the last clock of the E-high phase. The load becomes visible one clock after the first clock that samples `e_phase` = 0. All other address bits in the page are ignored.
- R7: A read cycle (`rw`=1) to $8xxx with address bit 2 = 1 sets `ad_oe`=1 and `ad_out`=`ext_in` while `e_phase` is 1. Otherwise `ad_oe` is 0 and `ad_out` is 0.
- R8: At most one of the eight selects and `ad_oe` is active at a time. $9000-$BFFF, and $1000-$7FFF under full decoding, assert nothing. A write to the input-port address and a read of the output-port address leave `out_port` unchanged.
- R9: An asynchronous active-low `rst_n` clears `out_port` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples every bus input |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_strobe | input | 1 | Address strobe: shared wires carry the low address byte |
| e_phase | input | 1 | Bus enable phase; data moves while high |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| addr_hi | input | 8 | High address byte |
| ad_in | input | 8 | Shared address/data wires as seen by the block |
| ext_in | input | 8 | External input pins |
| addr | output | 16 | Rebuilt full address |
| ram_cs | output | 4 | One select per 1K RAM bank |
| ram_we | output | 1 | RAM write strobe |
| rom_cs | output | 4 | One select per 4K ROM bank |
| rom_oe | output | 1 | ROM output enable |
| out_port | output | 8 | Output register value |
| ad_out | output | 8 | Value the block drives onto the shared wires |
| ad_oe | output | 1 | Drive enable for the shared wires |

## Verification
Full bus cycles are run against two instances at once, one with each decode setting. RAM addresses at $0xxx and at mirrored places such as $1400, $5C00 and $7FFF show whether bits 14:12 take part in the decode. Reads and writes to every ROM bank, including $FFFC, separate the bank decode from the direction-dependent enable. The shared wires are changed to junk after the strobe falls and again during a read data phase. This shows that the held low byte, not the live wires, forms the address. I/O writes and reads at aliased addresses ($800B, $800D), writes to the input address and reads of the output address show that only bit 2 and the direction choose the action, and a mid-run reset shows the output register clearing at once.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 8;
  localparam int RAM_BANKS   = 4;
  localparam int ROM_BANKS   = 4;
  localparam int RAM_BANK_W  = $clog2(RAM_BANKS);
  localparam int ROM_BANK_W  = $clog2(ROM_BANKS);
  localparam int RAM_SEL_LSB = 10;
  localparam int ROM_SEL_LSB = 12;
  localparam int IO_SEL_BIT  = 2;
  localparam int LO_W        = ADDR_W - DATA_W;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_ROM  = 2'd2,
    RGN_IO   = 2'd3
  } region_e;

  // Map an address to its region; the top nibble carries the whole decision.
  function automatic region_e region_of(input logic [ADDR_W-1:0] a, input bit full);
    logic [3:0] nib;
    nib = a[ADDR_W-1 -: 4];
    if (nib[3:2] == 2'b11)                     return RGN_ROM;
    else if (nib == 4'h8)                      return RGN_IO;
    else if (full ? (nib == 4'h0) : !nib[3])   return RGN_RAM;
    else                                       return RGN_NONE;
  endfunction

  function automatic logic [RAM_BANK_W-1:0] ram_bank_of(input logic [ADDR_W-1:0] a);
    return a[RAM_SEL_LSB +: RAM_BANK_W];
  endfunction

  function automatic logic [ROM_BANK_W-1:0] rom_bank_of(input logic [ADDR_W-1:0] a);
    return a[ROM_SEL_LSB +: ROM_BANK_W];
  endfunction
endpackage

// File: rtl/bdm_addr_latch.sv
module bdm_addr_latch
  import bdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_strobe,
  input  logic [DATA_W-1:0] lo_in,
  input  logic [LO_W-1:0]   hi_in,
  output logic [ADDR_W-1:0] addr
);
  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] lo_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held_q <= '0;
    else if (as_strobe) held_q <= lo_in;
  end

  // Transparent while the strobe is high, held afterwards.
  assign lo_now = as_strobe ? lo_in : held_q;
  assign addr   = {hi_in, lo_now};
endmodule

// File: rtl/bdm_bank_select.sv
module bdm_bank_select #(
  parameter int N = 4
) (
  input  logic                                en,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0] idx,
  output logic [N-1:0]                        sel
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel[g] = en && (idx == IW'(g));
  end
endmodule

// File: rtl/bdm_mem_decode.sv
module bdm_mem_decode
  import bdm_pkg::*;
#(
  parameter bit FULL_RAM_DECODE = 1'b1
) (
  input  logic                 e_phase,
  input  logic                 rw,
  input  logic [ADDR_W-1:0]    addr,
  output logic [RAM_BANKS-1:0] ram_cs,
  output logic                 ram_we,
  output logic [ROM_BANKS-1:0] rom_cs,
  output logic                 rom_oe,
  output logic                 io_wr_hit,
  output logic                 io_rd_hit
);
  region_e                rgn;
  logic                   ram_en;
  logic                   rom_en;
  logic [RAM_BANK_W-1:0]  ram_idx;
  logic [ROM_BANK_W-1:0]  rom_idx;

  assign rgn     = region_of(addr, FULL_RAM_DECODE);
  assign ram_en  = e_phase && (rgn == RGN_RAM);
  assign rom_en  = e_phase && (rgn == RGN_ROM);
  assign ram_idx = ram_bank_of(addr);
  assign rom_idx = rom_bank_of(addr);

  bdm_bank_select #(.N(RAM_BANKS)) u_ram_sel (
    .en  (ram_en),
    .idx (ram_idx),
    .sel (ram_cs)
  );

  bdm_bank_select #(.N(ROM_BANKS)) u_rom_sel (
    .en  (rom_en),
    .idx (rom_idx),
    .sel (rom_cs)
  );

  assign ram_we    = ram_en && !rw;
  assign rom_oe    = rom_en && rw;
  assign io_wr_hit = (rgn == RGN_IO) && !addr[IO_SEL_BIT] && !rw;
  assign io_rd_hit = e_phase && (rgn == RGN_IO) && addr[IO_SEL_BIT] && rw;
endmodule

// File: rtl/bdm_io_port.sv
module bdm_io_port
  import bdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_phase,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [DATA_W-1:0] ext_in,
  input  logic              wr_hit,
  input  logic              rd_hit,
  output logic              e_fall,
  output logic [DATA_W-1:0] out_port,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  logic              e_q;
  logic              wr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] out_q;

  assign e_fall = e_q && !e_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q    <= 1'b0;
      wr_q   <= 1'b0;
      data_q <= '0;
      out_q  <= '0;
    end else begin
      e_q <= e_phase;
      if (e_phase) begin
        data_q <= ad_in;
        wr_q   <= wr_hit;
      end
      if (e_fall && wr_q) out_q <= data_q;
    end
  end

  assign out_port = out_q;
  assign ad_oe    = rd_hit;
  assign ad_out   = rd_hit ? ext_in : '0;
endmodule

// File: rtl/bus_demux_decoder.sv
module bus_demux_decoder
  import bdm_pkg::*;
#(
  parameter bit FULL_RAM_DECODE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 as_strobe,
  input  logic                 e_phase,
  input  logic                 rw,
  input  logic [LO_W-1:0]      addr_hi,
  input  logic [DATA_W-1:0]    ad_in,
  input  logic [DATA_W-1:0]    ext_in,
  output logic [ADDR_W-1:0]    addr,
  output logic [RAM_BANKS-1:0] ram_cs,
  output logic                 ram_we,
  output logic [ROM_BANKS-1:0] rom_cs,
  output logic                 rom_oe,
  output logic [DATA_W-1:0]    out_port,
  output logic [DATA_W-1:0]    ad_out,
  output logic                 ad_oe
);
  logic io_wr_hit;
  logic io_rd_hit;
  logic e_fall;

  bdm_addr_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_strobe (as_strobe),
    .lo_in     (ad_in),
    .hi_in     (addr_hi),
    .addr      (addr)
  );

  bdm_mem_decode #(.FULL_RAM_DECODE(FULL_RAM_DECODE)) u_dec (
    .e_phase   (e_phase),
    .rw        (rw),
    .addr      (addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .rom_cs    (rom_cs),
    .rom_oe    (rom_oe),
    .io_wr_hit (io_wr_hit),
    .io_rd_hit (io_rd_hit)
  );

  bdm_io_port u_io (
    .clk      (clk),
    .rst_n    (rst_n),
    .e_phase  (e_phase),
    .ad_in    (ad_in),
    .ext_in   (ext_in),
    .wr_hit   (io_wr_hit),
    .rd_hit   (io_rd_hit),
    .e_fall   (e_fall),
    .out_port (out_port),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe)
  );
endmodule

// File: rtl/bdm_checker.sv
module bdm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        as_strobe,
  input logic        e_phase,
  input logic        rw,
  input logic [7:0]  addr_hi,
  input logic [15:0] addr,
  input logic [3:0]  ram_cs,
  input logic        ram_we,
  input logic [3:0]  rom_cs,
  input logic        rom_oe,
  input logic [7:0]  out_port,
  input logic        ad_oe
);
  a_r1_high_byte_direct: assert property (@(posedge clk) disable iff (!rst_n)
    addr[15:8] == addr_hi);

  a_r1_low_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_strobe && $past(!as_strobe)) |-> $stable(addr[7:0]));

  a_r2_no_select_without_e: assert property (@(posedge clk) disable iff (!rst_n)
    !e_phase |-> (ram_cs == 4'b0 && rom_cs == 4'b0 && !ad_oe));

  a_r5_ram_write_direction: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!rw && ram_cs != 4'b0));

  a_r5_rom_enable_direction: assert property (@(posedge clk) disable iff (!rst_n)
    rom_oe |-> (rw && rom_cs != 4'b0));

  a_r6_load_only_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(e_phase) |=> $stable(out_port));

  a_r7_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (rw && e_phase && addr[15:12] == 4'h8));

  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, rom_cs, ad_oe}));

  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |-> out_port == 8'h00);
endmodule

bind bus_demux_decoder bdm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .as_strobe (as_strobe),
  .e_phase   (e_phase),
  .rw        (rw),
  .addr_hi   (addr_hi),
  .addr      (addr),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .rom_cs    (rom_cs),
  .rom_oe    (rom_oe),
  .out_port  (out_port),
  .ad_oe     (ad_oe)
);

// File: tb/bus_demux_decoder_tb.sv
module bus_demux_decoder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b1;
  logic       as_strobe = 1'b0;
  logic       e_phase = 1'b0;
  logic       rw = 1'b1;
  logic [7:0] addr_hi = 8'h00;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ext_in = 8'h00;

  logic [15:0] addr_f, addr_p;
  logic [3:0]  ram_cs_f, ram_cs_p, rom_cs_f, rom_cs_p;
  logic        ram_we_f, ram_we_p, rom_oe_f, rom_oe_p, ad_oe_f, ad_oe_p;
  logic [7:0]  out_f, out_p, ad_out_f, ad_out_p;

  bus_demux_decoder #(.FULL_RAM_DECODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .as_strobe(as_strobe), .e_phase(e_phase), .rw(rw),
    .addr_hi(addr_hi), .ad_in(ad_in), .ext_in(ext_in), .addr(addr_f),
    .ram_cs(ram_cs_f), .ram_we(ram_we_f), .rom_cs(rom_cs_f), .rom_oe(rom_oe_f),
    .out_port(out_f), .ad_out(ad_out_f), .ad_oe(ad_oe_f));

  bus_demux_decoder #(.FULL_RAM_DECODE(1'b0)) dut_p (
    .clk(clk), .rst_n(rst_n), .as_strobe(as_strobe), .e_phase(e_phase), .rw(rw),
    .addr_hi(addr_hi), .ad_in(ad_in), .ext_in(ext_in), .addr(addr_p),
    .ram_cs(ram_cs_p), .ram_we(ram_we_p), .rom_cs(rom_cs_p), .rom_oe(rom_oe_p),
    .out_port(out_p), .ad_out(ad_out_p), .ad_oe(ad_oe_p));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference state, kept as plain integers.
  int m_held = 0, m_data = 0, m_out = 0;
  bit m_eprev = 0, m_wr = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pop(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) & 1) c++;
    return c;
  endfunction

  task automatic check_inst(input string nm, input bit full,
      input int a_act, input int rcs, input int rwe, input int ocs, input int ooe,
      input int outv, input int adv, input int adoe);
    int lo, a, e_ram, e_rom, e_io, e_rcs, e_ocs, e_drv, sel_cnt;
    lo = as_strobe ? int'(ad_in) : m_held;
    a  = int'(addr_hi) * 256 + lo;
    e_ram = full ? (a < 4096) : (a < 32768);
    e_rom = (a >= 49152);
    e_io  = (a >= 32768) && (a < 36864);
    e_rcs = (e_phase && e_ram) ? (1 << ((a % 4096) / 1024)) : 0;
    e_ocs = (e_phase && e_rom) ? (1 << ((a - 49152) / 4096)) : 0;
    e_drv = e_phase && e_io && rw && ((a / 4) % 2 == 1);
    chk("R1", {nm, " addr"}, a_act, a);
    chk(full ? "R2" : "R3", {nm, " ram_cs"}, rcs, e_rcs);
    chk("R4", {nm, " rom_cs"}, ocs, e_ocs);
    chk("R5", {nm, " ram_we"}, rwe, (e_rcs != 0) && !rw);
    chk("R5", {nm, " rom_oe"}, ooe, (e_ocs != 0) && rw);
    chk(rst_n ? "R6" : "R9", {nm, " out_port"}, outv, m_out);
    chk("R7", {nm, " ad_oe"}, adoe, e_drv);
    chk("R7", {nm, " ad_out"}, adv, e_drv ? int'(ext_in) : 0);
    sel_cnt = pop(rcs) + pop(ocs) + adoe;
    chk("R8", {nm, " active selects"}, sel_cnt, (e_rcs != 0) + (e_ocs != 0) + e_drv);
  endtask

  // One system clock: drive, settle, compare, advance the reference.
  task automatic step(input bit rst_v, input bit s, input bit e, input bit r,
                      input logic [7:0] hi, input logic [7:0] d, input logic [7:0] x);
    int a, lo;
    bit fall;
    @(posedge clk);
    #1;
    rst_n = rst_v; as_strobe = s; e_phase = e; rw = r; addr_hi = hi; ad_in = d; ext_in = x;
    if (!rst_v) begin
      m_held = 0; m_data = 0; m_out = 0; m_eprev = 0; m_wr = 0;
    end
    #1;
    check_inst("full", 1'b1, addr_f, ram_cs_f, ram_we_f, rom_cs_f, rom_oe_f, out_f, ad_out_f, ad_oe_f);
    check_inst("part", 1'b0, addr_p, ram_cs_p, ram_we_p, rom_cs_p, rom_oe_p, out_p, ad_out_p, ad_oe_p);
    if (rst_v) begin
      lo = s ? int'(d) : m_held;
      a  = int'(hi) * 256 + lo;
      fall = !e && m_eprev;
      if (fall && m_wr) m_out = m_data;
      if (s) m_held = int'(d);
      if (e) begin
        m_data = int'(d);
        m_wr = (a >= 32768) && (a < 36864) && ((a / 4) % 2 == 0) && !r;
      end
      m_eprev = e;
    end
  endtask

  // A complete bus cycle: strobe phase, hold phase, two E-high clocks, E low.
  task automatic bus_cycle(input logic [15:0] a, input bit r, input logic [7:0] wdata,
                           input logic [7:0] pins);
    logic [7:0] dph;
    dph = r ? 8'hEE : wdata;
    step(1, 1, 0, r, a[15:8], a[7:0], pins);
    step(1, 0, 0, r, a[15:8], ~a[7:0], pins);
    step(1, 0, 1, r, a[15:8], dph, pins);
    step(1, 0, 1, r, a[15:8], dph, pins);
    step(1, 0, 0, r, a[15:8], 8'h33, pins);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // R9: reset state
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    // R2, R5: RAM banks read and write
    bus_cycle(16'h0000, 1, 8'h00, 8'h00);
    bus_cycle(16'h07FF, 1, 8'h00, 8'h00);
    bus_cycle(16'h0A10, 0, 8'h11, 8'h00);
    bus_cycle(16'h0FFF, 0, 8'h22, 8'h00);
    // R3: mirrors answer only under partial decode
    bus_cycle(16'h1400, 1, 8'h00, 8'h00);
    bus_cycle(16'h5C00, 0, 8'h44, 8'h00);
    bus_cycle(16'h7FFF, 1, 8'h00, 8'h00);
    // R4, R5: ROM banks, vectors, write cycle
    bus_cycle(16'hC000, 1, 8'h00, 8'h00);
    bus_cycle(16'hD123, 1, 8'h00, 8'h00);
    bus_cycle(16'hE800, 0, 8'h55, 8'h00);
    bus_cycle(16'hFFFC, 1, 8'h00, 8'h00);
    // R8: unmapped holes
    bus_cycle(16'h9000, 1, 8'h00, 8'hF0);
    bus_cycle(16'hA123, 0, 8'h66, 8'h00);
    bus_cycle(16'hBFFF, 1, 8'h00, 8'h0F);
    // R6: output port and its aliases
    bus_cycle(16'h8000, 0, 8'hA5, 8'h00);
    bus_cycle(16'h800B, 0, 8'h3C, 8'h00);
    // R7: input port and its aliases
    bus_cycle(16'h8004, 1, 8'h00, 8'h5A);
    bus_cycle(16'h800D, 1, 8'h00, 8'hC3);
    // R8: write to input address, read of output address: no change
    bus_cycle(16'h8004, 0, 8'h99, 8'h77);
    bus_cycle(16'h8000, 1, 8'h00, 8'h77);
    bus_cycle(16'h8FF8, 0, 8'h81, 8'h00);
    // R9: reset in the middle of a run
    step(0, 0, 0, 1, 8'h80, 8'h00, 8'h00);
    step(1, 0, 0, 1, 8'h80, 8'h00, 8'h00);
    // R1: strobe held high over changing wires, then hold
    step(1, 1, 0, 1, 8'h12, 8'h34, 8'h00);
    step(1, 1, 0, 1, 8'h12, 8'h56, 8'h00);
    step(1, 0, 0, 1, 8'h12, 8'h78, 8'h00);
    step(1, 0, 0, 1, 8'hC4, 8'h9A, 8'h00);
    bus_cycle(16'h8000, 0, 8'h5E, 8'h00);
    step(1, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule